// File: doc/BRIEF.md
# Banked Parallel Dot-Product Engine

This block computes the fixed-point inner product of two 512-element vectors, called X and Y, of signed 12-bit values. Both vectors live in memories inside the block. Each vector is split into four banks so that four consecutive elements of each vector can be fetched in the same cycle. Four multiplier lanes form the products of one group of four element pairs. Each product is scaled down by an arithmetic shift. A balanced adder tree combines the four scaled products and adds the total to a 16-bit running sum. A new group enters the pipeline every cycle.

Software or a sequencer first fills the two vectors through a simple element-write port. It then pulses `start`. The engine walks all 128 groups through its three pipeline stages: bank read, multiply and scale, then tree add and accumulate. When the last group has drained, the engine pulses `done` for one cycle and presents the 16-bit sum on `result`. `result` holds that value until the next run completes.

Top module: `dotprod_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy` and `done` are 0 and `result` is 0.
- R2: A write with `ld_sel`=0 targets X and a write with `ld_sel`=1 targets Y. Element `ld_idx`=k goes to bank k mod 4 at word k div 4. The result pairs X[k] with Y[k] for every k in 0..511.
- R3: Each 24-bit signed product X[k]*Y[k] is shifted right arithmetically by 8 (rounding toward minus infinity) before it is summed.
- R4: The running sum is 16 bits wide and wraps modulo 2^16 on overflow.
- R5: A `start` pulse while idle clears the running sum. Repeated runs over unchanged vectors give the same result.
- R6: `done` is high for exactly one cycle, 130 clock edges after the edge that samples `start`. `result` takes the new sum in that same cycle and holds it until the next `done`.
- R7: `busy` is 1 from the edge that samples `start` until the edge that raises `done`. At that edge `busy` returns to 0.
- R8: Element writes presented while `busy` is 1 leave both vectors unchanged.
- R9: A `start` pulse while `busy` is 1 is ignored. The run in progress keeps its timing, and only one `done` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Element write strobe |
| ld_sel | input | 1 | Vector select: 0 = X, 1 = Y |
| ld_idx | input | 9 | Element index 0..511 |
| ld_data | input | 12 | Signed element value |
| start | input | 1 | Begin a run (sampled when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Wrapped dot-product sum, registered |

## Verification
The sum of the last group reaches the accumulator three edges after that group is issued. `done` and `result` therefore change together on the 130th edge after the start edge. The bench counts falling edges from the start edge, requires the first `done` at exactly count 130, and reads `result` and `busy` at that same falling edge. It keeps watching for at least ten more cycles to confirm the pulse is single, and much longer when a stray `start` has been injected. Writes poked during a run are judged by rerunning the same vectors and comparing against the unchanged model.

// File: rtl/dp_pkg.sv
package dp_pkg;
  typedef enum logic {VEC_X = 1'b0, VEC_Y = 1'b1} vec_sel_e;
  typedef enum logic {CT_IDLE = 1'b0, CT_RUN = 1'b1} ctl_state_e;
endpackage

// File: rtl/dp_bank.sv
module dp_bank #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual-port RAM with registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dp_lane.sv
module dp_lane #(
  parameter int ELEM_W = 12,
  parameter int SHIFT  = 8,
  localparam int PW    = 2 * ELEM_W,
  localparam int OUT_W = PW - SHIFT
) (
  input  logic                    clk,
  input  logic signed [ELEM_W-1:0] a,
  input  logic signed [ELEM_W-1:0] b,
  output logic signed [OUT_W-1:0]  p_out
);
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;

  assign prod   = a * b;
  assign scaled = prod >>> SHIFT;

  always_ff @(posedge clk) begin
    p_out <= scaled[OUT_W-1:0];
  end
endmodule

// File: rtl/dp_tree.sv
module dp_tree #(
  parameter int N     = 4,
  parameter int IN_W  = 16,
  parameter int OUT_W = 18,
  localparam int LV   = $clog2(N)
) (
  input  logic signed [IN_W-1:0]  din [N],
  output logic signed [OUT_W-1:0] sum
);
  for (genvar lv = 0; lv <= LV; lv++) begin : g_lv
    localparam int CNT = N >> lv;
    logic signed [OUT_W-1:0] s [CNT];
    for (genvar j = 0; j < CNT; j++) begin : g_n
      if (lv == 0) begin : g_leaf
        assign s[j] = OUT_W'(din[j]);
      end else begin : g_add
        assign s[j] = g_lv[lv-1].s[2*j] + g_lv[lv-1].s[2*j+1];
      end
    end
  end

  assign sum = g_lv[LV].s[0];
endmodule

// File: rtl/dp_ctrl.sv
module dp_ctrl
  import dp_pkg::*;
#(
  parameter int GROUPS = 128,
  localparam int GW    = $clog2(GROUPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          clr,
  output logic [GW-1:0] raddr,
  output logic          prod_vld,
  output logic          prod_last,
  output logic          done
);
  localparam logic [GW-1:0] LAST = GW'(GROUPS - 1);

  ctl_state_e    st;
  logic          issuing;
  logic [GW-1:0] grp;
  logic          rd_vld, rd_last;

  assign busy  = (st == CT_RUN);
  assign clr   = start && (st == CT_IDLE);
  assign raddr = grp;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= CT_IDLE;
      issuing   <= 1'b0;
      grp       <= '0;
      rd_vld    <= 1'b0;
      rd_last   <= 1'b0;
      prod_vld  <= 1'b0;
      prod_last <= 1'b0;
      done      <= 1'b0;
    end else begin
      rd_vld    <= issuing;
      rd_last   <= issuing && (grp == LAST);
      prod_vld  <= rd_vld;
      prod_last <= rd_last;
      done      <= prod_vld && prod_last;
      if (clr) begin
        st      <= CT_RUN;
        issuing <= 1'b1;
        grp     <= '0;
      end else begin
        if (issuing) begin
          if (grp == LAST) issuing <= 1'b0;
          else             grp     <= grp + 1'b1;
        end
        if (prod_vld && prod_last) st <= CT_IDLE;
      end
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_group_step_R9: assert property (@(posedge clk) disable iff (rst)
    (issuing && grp != LAST) |=> (grp == $past(grp) + 1'b1));
  assert_pipe_order_R6: assert property (@(posedge clk) disable iff (rst)
    prod_vld |-> $past(rd_vld));
endmodule

// File: rtl/dotprod_engine.sv
module dotprod_engine
  import dp_pkg::*;
#(
  parameter int ELEM_W = 12,
  parameter int N_ELEM = 512,
  parameter int LANES  = 4,
  parameter int SHIFT  = 8,
  parameter int ACC_W  = 16,
  localparam int IW     = $clog2(N_ELEM),
  localparam int LB     = $clog2(LANES),
  localparam int GROUPS = N_ELEM / LANES,
  localparam int GW     = $clog2(GROUPS),
  localparam int PRD_W  = 2 * ELEM_W - SHIFT,
  localparam int SUM_W  = PRD_W + LB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic              ld_sel,
  input  logic [IW-1:0]     ld_idx,
  input  logic [ELEM_W-1:0] ld_data,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [ACC_W-1:0]  result
);
  logic          clr, prod_vld, prod_last;
  logic [GW-1:0] raddr;
  logic          wr_ok;

  logic signed [PRD_W-1:0] lane_p [LANES];
  logic signed [SUM_W-1:0] tree_sum;
  logic [ACC_W-1:0]        acc, acc_nxt;

  dp_ctrl #(.GROUPS(GROUPS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .clr(clr),
    .raddr(raddr), .prod_vld(prod_vld), .prod_last(prod_last), .done(done)
  );

  assign wr_ok = ld_en && !busy;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ELEM_W-1:0] x_q, y_q;
    logic              hit;
    assign hit = wr_ok && (ld_idx[LB-1:0] == LB'(l));

    dp_bank #(.DATA_W(ELEM_W), .DEPTH(GROUPS)) u_bank_x (
      .clk(clk), .we(hit && (ld_sel == VEC_X)), .waddr(ld_idx[IW-1:LB]),
      .wdata(ld_data), .raddr(raddr), .rdata(x_q)
    );
    dp_bank #(.DATA_W(ELEM_W), .DEPTH(GROUPS)) u_bank_y (
      .clk(clk), .we(hit && (ld_sel == VEC_Y)), .waddr(ld_idx[IW-1:LB]),
      .wdata(ld_data), .raddr(raddr), .rdata(y_q)
    );
    dp_lane #(.ELEM_W(ELEM_W), .SHIFT(SHIFT)) u_mul (
      .clk(clk), .a($signed(x_q)), .b($signed(y_q)), .p_out(lane_p[l])
    );
  end

  dp_tree #(.N(LANES), .IN_W(PRD_W), .OUT_W(SUM_W)) u_tree (
    .din(lane_p), .sum(tree_sum)
  );

  assign acc_nxt = acc + ACC_W'(tree_sum);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      result <= '0;
    end else begin
      if (clr)           acc <= '0;
      else if (prod_vld) acc <= acc_nxt;
      if (prod_vld && prod_last) result <= acc_nxt;
    end
  end

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
endmodule

// File: tb/tb_dotprod_engine.sv
module tb_dotprod_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 512;
  localparam int NV = 6;
  // stimulus table: {mode, seed}
  localparam logic [15:0] VEC [NV] = '{
    {4'd0, 12'd5}, {4'd0, 12'd1234}, {4'd1, 12'd0},
    {4'd2, 12'd6}, {4'd2, 12'd509}, {4'd3, 12'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0, ld_sel = 1'b0, start = 1'b0;
  logic [8:0]  ld_idx = '0;
  logic [11:0] ld_data = '0;
  logic busy, done;
  logic [15:0] result;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int mx [NE];
  int my [NE];

  always #(CLK_PERIOD/2) clk = ~clk;

  dotprod_engine dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_idx(ld_idx),
    .ld_data(ld_data), .start(start), .busy(busy), .done(done), .result(result)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int gen_val(int mode, int seed, int k, bit sel);
    case (mode)
      0: return sel ? ((k*k*3 + seed*k + 29) % 4096) - 2048
                    : ((k*seed*7 + 113*k + seed) % 4096) - 2048;
      1: return sel ? 2047 : -2048;
      2: return sel ? (k*5 - 1000) : ((k == seed) ? 1500 : 0);
      default: return sel ? -1 : 1;
    endcase
  endfunction

  function automatic int model();
    int acc = 0;
    for (int k = 0; k < NE; k++) begin
      int p = mx[k] * my[k];
      acc = (acc + (p >>> 8)) & 32'hFFFF;
    end
    return acc;
  endfunction

  task automatic load_vectors(int mode, int seed);
    for (int k = 0; k < NE; k++) begin
      mx[k] = gen_val(mode, seed, k, 1'b0);
      my[k] = gen_val(mode, seed, k, 1'b1);
    end
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < NE; k++) begin
        @(negedge clk);
        ld_en = 1'b1; ld_sel = s[0]; ld_idx = 9'(k);
        ld_data = 12'(s == 0 ? mx[k] : my[k]);
      end
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // start_at: cycle to inject a stray start (-1 none); poke: write during run
  task automatic run_check(string req, int start_at, bit poke, int ncyc);
    int first_done = -1;
    int dones = 0;
    int exp = model();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int n = 1; n <= ncyc; n++) begin
      @(negedge clk);
      if (n == 1) check("R7 busy after start", int'(busy), 1);
      if (done) begin
        dones++;
        if (first_done < 0) begin
          first_done = n;
          check("R7 busy low at done", int'(busy), 0);
          check(req, int'(result), exp);
        end
      end
      start   = (n == start_at);
      ld_en   = poke && (n >= 5) && (n < 25);
      ld_sel  = n[0];
      ld_idx  = 9'(n * 3);
      ld_data = 12'h7FF;
    end
    start = 1'b0; ld_en = 1'b0;
    check("R6 done latency", first_done, 130);
    check("R6 R9 single done", dones, 1);
    check("R6 result held", int'(result), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 done in reset", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 result", int'(result), 0);

    // table walk: R2 mapping (spikes), R3 floor shift (mode 3), R4 wrap (mode 1)
    for (int v = 0; v < NV; v++) begin
      load_vectors(int'(VEC[v][15:12]), int'(VEC[v][11:0]));
      run_check(v == 5 ? "R3 floor shift" : v == 2 ? "R4 wrap" :
                v >= 3 ? "R2 bank mapping" : "R2 mixed vectors", -1, 1'b0, 140);
    end

    // R8: writes during a run, then R5 rerun on unchanged vectors
    load_vectors(0, 77);
    run_check("R8 run with pokes", -1, 1'b1, 140);
    run_check("R8 R5 rerun unchanged", -1, 1'b0, 140);

    // R9: stray start mid-run
    run_check("R9 stray start", 60, 1'b0, 300);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule